// File: doc/BRIEF.md
# Per-Block Write Protection Manager

This block holds the protection state of the 23 erase blocks of a boot-block flash array and decides, for any target word address, whether a program or erase may proceed. The array has 15 main blocks of 32K words and 8 parameter blocks of 4K words. A parameter selects whether the parameter blocks sit at the highest or the lowest addresses. Block indices always count upward with address.

Each block carries a lock bit and a lock-down bit. Lock, unlock and lock-down requests arrive with a word address and a one-cycle valid strobe. A write-protect input decides whether lock-down is in force. While that input is low, a locked-down block cannot be unlocked and is treated as locked. While it is high, the block can be unlocked and relocked freely, and it returns to the locked state once the input falls again. Only a hardware reset clears lock-down. A separate program-enable input models a supply lockout that denies every block. A status port returns the two bits of any block combinationally.

Top module: `lock_guard`

## Requirements
- R1: `chk_blk` gives the block index of `chk_addr`, where bits [18:15] select a 32K-word region and bits [14:12] select a 4K-word slice. With TOP_BOOT=1, regions 0..14 map to blocks 0..14 and region 15 maps to blocks 15+slice. With TOP_BOOT=0, region 0 maps to blocks 0..7 by slice, and region r>0 maps to block 7+r.
- R2: While `rst_n` is low, and after it rises, every block reads status 2'b01: locked, not locked down.
- R3: On `req_op` 2'b01 (lock) or 2'b10 (unlock) with `req_valid`, the addressed block's lock bit is set or cleared at the next clock edge. Op 2'b00 changes nothing.
- R4: On `req_op` 2'b11 (lock-down) with `req_valid`, the addressed block's lock-down and lock bits are both set at the next clock edge, whatever the state of `wp_n`.
- R5: No request clears a lock-down bit. Only reset clears it.
- R6: While `wp_n` is low, lock and unlock requests on a locked-down block are ignored, and the block is protected.
- R7: While `wp_n` is high, a locked-down block can be unlocked to status 2'b10 and relocked to 2'b11.
- R8: When `wp_n` is low, every locked-down block reads lock bit 1 and is protected at once. Its stored lock bit is set by the next clock edge, so it stays locked if `wp_n` rises again.
- R9: `chk_prot_err` is 1 when the block at `chk_addr` is locked. `chk_allow` is 1 only when that block is unlocked and `prog_en` is 1.
- R10: With `prog_en` low, `chk_allow` is 0 for every address, and `chk_prot_err` still reflects the lock bit.
- R11: `stat_lock` is {lock-down, lock} for block `stat_idx`, read combinationally. An index of 23 or above reads 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wp_n | input | 1 | Write protect: low enforces lock-down |
| prog_en | input | 1 | Supply lockout: low denies all program and erase |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 01 lock, 10 unlock, 11 lock-down, 00 none |
| req_addr | input | 19 | Word address selecting the request's block |
| chk_addr | input | 19 | Target address of a program or erase |
| chk_blk | output | 5 | Block index of `chk_addr` |
| chk_allow | output | 1 | Program or erase is permitted |
| chk_prot_err | output | 1 | Target block is locked (protection error) |
| stat_idx | input | 5 | Block index to read |
| stat_lock | output | 2 | {lock-down, lock} of block `stat_idx` |

## Verification
The bound checker checks on every cycle that lock-down bits never fall outside reset, and that a permit never appears without program enable or while a protection error is raised. It also checks that an enforced locked-down target is always denied, that a lock-down request sets both bits, and that an out-of-range status index reads zero. Three behaviours need ordered scenarios, so only the bench shows them. These are the address-to-block mapping for both layouts, swept over every 4K slice; the unlock-then-relock sequence while write-protect is high; and the lock bit persisting after write-protect falls and rises again.

// File: rtl/lock_guard.sv
module lock_guard #(
  parameter bit TOP_BOOT = 1'b1,
  parameter int NPARAM   = 8,
  parameter int NMAIN    = 15,
  parameter int MAIN_W   = 15
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    wp_n,
  input  logic                                    prog_en,
  input  logic                                    req_valid,
  input  logic [1:0]                              req_op,
  input  logic [MAIN_W+$clog2(NMAIN+1)-1:0]       req_addr,
  input  logic [MAIN_W+$clog2(NMAIN+1)-1:0]       chk_addr,
  output logic [$clog2(NPARAM+NMAIN)-1:0]         chk_blk,
  output logic                                    chk_allow,
  output logic                                    chk_prot_err,
  input  logic [$clog2(NPARAM+NMAIN)-1:0]         stat_idx,
  output logic [1:0]                              stat_lock
);
  localparam int NBLK   = NPARAM + NMAIN;
  localparam int IDX_W  = $clog2(NBLK);
  localparam int HI_W   = $clog2(NMAIN + 1);
  localparam int SL_W   = $clog2(NPARAM);
  localparam int ADDR_W = MAIN_W + HI_W;

  logic [NBLK-1:0]  lock_q, ld_q, eff_lock;
  logic [IDX_W-1:0] req_blk;

  function automatic logic [IDX_W-1:0] blk_of(input logic [ADDR_W-1:0] a);
    logic [HI_W-1:0] hi;
    logic [SL_W-1:0] sl;
    hi = a[ADDR_W-1 -: HI_W];
    sl = a[MAIN_W-1 -: SL_W];
    if (TOP_BOOT)
      return (hi == HI_W'(NMAIN)) ? IDX_W'(NMAIN) + IDX_W'(sl) : IDX_W'(hi);
    else
      return (hi == '0) ? IDX_W'(sl) : IDX_W'(NPARAM - 1) + IDX_W'(hi);
  endfunction

  assign req_blk  = blk_of(req_addr);
  assign chk_blk  = blk_of(chk_addr);
  assign eff_lock = lock_q | (ld_q & {NBLK{~wp_n}});

  assign chk_prot_err = eff_lock[chk_blk];
  assign chk_allow    = prog_en & ~chk_prot_err;
  assign stat_lock    = (32'(stat_idx) < NBLK) ? {ld_q[stat_idx], eff_lock[stat_idx]} : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= '1;
      ld_q   <= '0;
    end else begin
      if (!wp_n) lock_q <= lock_q | ld_q;
      if (req_valid) begin
        case (req_op)
          2'b01: if (wp_n || !ld_q[req_blk]) lock_q[req_blk] <= 1'b1;
          2'b10: if (wp_n || !ld_q[req_blk]) lock_q[req_blk] <= 1'b0;
          2'b11: begin
            lock_q[req_blk] <= 1'b1;
            ld_q[req_blk]   <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/lock_guard_chk.sv
module lock_guard_chk #(
  parameter int NBLK  = 23,
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wp_n,
  input logic             prog_en,
  input logic             req_valid,
  input logic [1:0]       req_op,
  input logic [IDX_W-1:0] req_blk,
  input logic [NBLK-1:0]  lock_q,
  input logic [NBLK-1:0]  ld_q,
  input logic [IDX_W-1:0] chk_blk,
  input logic             chk_allow,
  input logic             chk_prot_err,
  input logic [IDX_W-1:0] stat_idx,
  input logic [1:0]       stat_lock
);
  assert_ld_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(ld_q) & ~ld_q) == '0));

  assert_supply_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    chk_allow |-> prog_en);

  assert_prot_deny_R9: assert property (@(posedge clk) disable iff (!rst_n)
    chk_allow |-> !chk_prot_err);

  assert_enforced_deny_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_n && ld_q[chk_blk]) |-> !chk_allow);

  assert_lockdown_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'b11) |=> (ld_q[$past(req_blk)] && lock_q[$past(req_blk)]));

  assert_wp_relock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_n && stat_lock[1]) |-> stat_lock[0]);

  assert_idx_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(stat_idx) >= NBLK) |-> (stat_lock == 2'b00));
endmodule

bind lock_guard lock_guard_chk #(.NBLK(NBLK), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .prog_en(prog_en),
  .req_valid(req_valid), .req_op(req_op), .req_blk(req_blk),
  .lock_q(lock_q), .ld_q(ld_q), .chk_blk(chk_blk), .chk_allow(chk_allow),
  .chk_prot_err(chk_prot_err), .stat_idx(stat_idx), .stat_lock(stat_lock)
);

// File: tb/lock_guard_tb.sv
module lock_guard_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wp_n = 1'b1;
  logic        prog_en = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'b00;
  logic [18:0] req_addr = '0;
  logic [18:0] chk_addr = '0;
  logic [4:0]  stat_idx = '0;
  logic [4:0]  chk_blk, chk_blk_b;
  logic        chk_allow, chk_prot_err, allow_b, perr_b;
  logic [1:0]  stat_lock, stat_b;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  lock_guard #(.TOP_BOOT(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .prog_en(prog_en),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .chk_addr(chk_addr), .chk_blk(chk_blk), .chk_allow(chk_allow),
    .chk_prot_err(chk_prot_err), .stat_idx(stat_idx), .stat_lock(stat_lock));

  lock_guard #(.TOP_BOOT(1'b0)) u_dut_bot (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .prog_en(prog_en),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .chk_addr(chk_addr), .chk_blk(chk_blk_b), .chk_allow(allow_b),
    .chk_prot_err(perr_b), .stat_idx(stat_idx), .stat_lock(stat_b));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [18:0] addr_of(input int b);
    if (b < 15) return 19'(b << 15);
    return 19'((15 << 15) | ((b - 15) << 12));
  endfunction

  task automatic req(input logic [1:0] op, input int b);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = addr_of(b);
    @(negedge clk);
    req_valid = 1'b0; req_op = 2'b00;
  endtask

  task automatic stat_is(input int b, input int exp, input string tag);
    stat_idx = 5'(b); #1;
    check(stat_lock == 2'(exp), tag, int'(stat_lock), exp);
  endtask

  task automatic allow_is(input int b, input int exp_allow, input int exp_err, input string tag);
    chk_addr = addr_of(b); #1;
    check(chk_allow == exp_allow[0], tag, int'(chk_allow), exp_allow);
    check(chk_prot_err == exp_err[0], tag, int'(chk_prot_err), exp_err);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int b = 0; b < 23; b++) stat_is(b, 1, "R2 in reset");
    do_reset();
    for (int b = 0; b < 23; b++) stat_is(b, 1, "R2 after reset");
    for (int b = 23; b < 32; b++) stat_is(b, 0, "R11 out of range");

    for (int k = 0; k < 128; k++) begin
      int hi, sl, et, eb;
      hi = k / 8; sl = k % 8;
      et = (hi == 15) ? 15 + sl : hi;
      eb = (hi == 0) ? sl : 7 + hi;
      chk_addr = 19'(k * 4096 + (k * 37) % 4096); #1;
      check(chk_blk == 5'(et), "R1 top layout", int'(chk_blk), et);
      check(chk_blk_b == 5'(eb), "R1 bottom layout", int'(chk_blk_b), eb);
    end

    allow_is(0, 0, 1, "R9 locked after reset");
    for (int b = 0; b < 23; b++) req(2'b10, b);
    for (int b = 0; b < 23; b++) stat_is(b, 0, "R3 unlock");
    for (int b = 0; b < 23; b++) allow_is(b, 1, 0, "R9 unlocked allowed");
    req(2'b01, 3);
    stat_is(3, 1, "R3 lock");
    stat_is(4, 0, "R3 neighbour untouched");
    allow_is(3, 0, 1, "R9 locked denied");
    req(2'b00, 3);
    stat_is(3, 1, "R3 no-op op");

    @(negedge clk); prog_en = 1'b0;
    for (int b = 0; b < 23; b++) if (b != 3) allow_is(b, 0, 0, "R10 supply lockout");
    allow_is(3, 0, 1, "R10 lock still reported");
    @(negedge clk); prog_en = 1'b1;

    @(negedge clk); wp_n = 1'b0;
    req(2'b11, 20);
    stat_is(20, 3, "R4 lock-down sets both");
    req(2'b10, 20);
    stat_is(20, 3, "R6 unlock ignored");
    allow_is(20, 0, 1, "R6 protected");
    req(2'b01, 20);
    stat_is(20, 3, "R6 lock ignored");
    req(2'b11, 12);
    stat_is(12, 3, "R4 lock-down on unlocked block");

    @(negedge clk); wp_n = 1'b1;
    req(2'b10, 20);
    stat_is(20, 2, "R7 unlock with wp high");
    allow_is(20, 1, 0, "R7 allowed while unlocked");
    req(2'b01, 20);
    stat_is(20, 3, "R7 relock");
    req(2'b10, 20);
    stat_is(20, 2, "R5 unlock keeps lock-down");

    @(negedge clk); wp_n = 1'b0; #1;
    stat_is(20, 3, "R8 immediate relock");
    allow_is(20, 0, 1, "R8 protected at once");
    @(negedge clk); wp_n = 1'b1;
    stat_is(20, 3, "R8 lock kept after wp high");
    stat_is(12, 3, "R8 other block kept");

    do_reset();
    stat_is(20, 1, "R5 reset clears lock-down");
    stat_is(12, 1, "R2 reset relocks");
    stat_is(3, 1, "R2 reset relocks");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule